// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter Stage

This block is one four-bit counting stage that steps up or down by one on each rising clock edge while its active-low count enable is held low. A build-time parameter chooses a decimal modulus (0 to 9) or a binary modulus (0 to 15). An active-high clear forces the count to zero and an active-high load copies a four-bit preset value into the count. Both act at once, without waiting for a clock edge, and clear wins when both are high.

An active-low carry output marks the terminal state for the current direction while the stage is enabled. Wiring that output to the enable of the next more significant stage, with all stages on one clock, makes a chain of stages count as one wider synchronous counter. In decimal mode, values 10 to 15 can only be reached by a load. The stage leaves them on the first enabled edge.

Each enabled edge is decided by one of seven named actions, chosen from the current value, the direction and the enable:
- `ACT_HOLD`: enable is high, so the value is kept.
- `ACT_INC`: step up by one.
- `ACT_DEC`: step down by one.
- `ACT_WRAP_LO`: step up from the top value to 0.
- `ACT_WRAP_HI`: step down from 0 to the top value.
- `ACT_FIX_LO`: step up from a decimal value above 9 to 0.
- `ACT_FIX_HI`: step down from a decimal value above 9 to 9.

Top module: `updn_stage`

## Requirements
- R1: A high `clear` sets `count` to 0 at once, with no clock edge, and it overrides `load_en`.
- R2: A high `load_en` with `clear` low copies `preset_val` into `count` at once, with no clock edge. Any value 0 to 15 is accepted, in either mode.
- R3: While `cin_n` is high, `count` keeps its value across clock edges.
- R4: While `cin_n` is low, each rising clock edge moves `count` one step: up when `count_up` is 1 and down when it is 0.
- R5: In decimal mode, stepping up from 9 gives 0 and stepping down from 0 gives 9.
- R6: In binary mode, stepping up from 15 gives 0 and stepping down from 0 gives 15.
- R7: `cout_n` is 0 exactly when `cin_n` is 0 and `count` is at the terminal value for the direction. The terminal value is the top value (9 in decimal, 15 in binary) when `count_up` is 1, and 0 when `count_up` is 0. Otherwise `cout_n` is 1.
- R8: In decimal mode, a `count` of 10 to 15 becomes 0 on the next enabled up edge and 9 on the next enabled down edge. It holds while `cin_n` is high, and it never drives `cout_n` low.
- R9: Two decimal stages share one clock, with the lower stage's `cout_n` wired to the upper stage's `cin_n`. Together they count 00 to 99 and wrap in both directions, one step per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; the count moves on the rising edge |
| clear | input | 1 | Active-high immediate clear to zero |
| load_en | input | 1 | Active-high immediate load of `preset_val` |
| preset_val | input | WIDTH | Value taken by a load |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n | input | 1 | Active-low count enable / carry input from a lower stage |
| count | output | WIDTH | Present count |
| cout_n | output | 1 | Active-low terminal-count carry to a higher stage |

## Verification
A wrong action choice shows on `count` at the first enabled edge after it occurs. In a chain it also shows one edge later on the upper stage, because `cout_n` gates that stage's steps. A carry decode that fires early or late shows up as the upper digit moving at the wrong decade boundary, so full 00 to 99 sweeps in both directions bring it out within one pass. Faults in decimal recovery stay hidden until a load places an illegal value. For that reason, loads of values above 9 are each followed by a single enabled edge in each direction, and the bench checks the result at that edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Action taken by one stage at the next rising clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_DEC,
        ACT_WRAP_LO,
        ACT_WRAP_HI,
        ACT_FIX_LO,
        ACT_FIX_HI
    } step_t;

endpackage

// File: rtl/updn_decide.sv
module updn_decide
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             cin_n,
    output step_t            act
);

    localparam int TOP_INT = DECIMAL ? 9 : (1 << WIDTH) - 1;
    localparam logic [WIDTH-1:0] TOP_VAL = TOP_INT[WIDTH-1:0];

    logic illegal;

    // Only the decimal variant has unreachable codes to recover from.
    generate
        if (DECIMAL) begin : g_dec
            assign illegal = (cur > TOP_VAL);
        end else begin : g_bin
            assign illegal = 1'b0;
        end
    endgenerate

    always_comb begin
        if (cin_n) begin
            act = ACT_HOLD;
        end else if (illegal) begin
            act = up ? ACT_FIX_LO : ACT_FIX_HI;
        end else if (up) begin
            act = (cur == TOP_VAL) ? ACT_WRAP_LO : ACT_INC;
        end else begin
            act = (cur == '0) ? ACT_WRAP_HI : ACT_DEC;
        end
    end

endmodule

// File: rtl/updn_apply.sv
module updn_apply
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  step_t            act,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP_INT = DECIMAL ? 9 : (1 << WIDTH) - 1;
    localparam logic [WIDTH-1:0] TOP_VAL = TOP_INT[WIDTH-1:0];

    always_comb begin
        unique case (act)
            ACT_HOLD:                nxt = cur;
            ACT_INC:                 nxt = cur + 1'b1;
            ACT_DEC:                 nxt = cur - 1'b1;
            ACT_WRAP_LO, ACT_FIX_LO: nxt = '0;
            ACT_WRAP_HI, ACT_FIX_HI: nxt = TOP_VAL;
            default:                 nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_term.sv
module updn_term #(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             cin_n,
    output logic             cout_n
);

    localparam int TOP_INT = DECIMAL ? 9 : (1 << WIDTH) - 1;
    localparam logic [WIDTH-1:0] TOP_VAL = TOP_INT[WIDTH-1:0];

    logic at_end;

    always_comb begin
        at_end = up ? (cur == TOP_VAL) : (cur == '0);
        cout_n = !(!cin_n && at_end);
    end

endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b1
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load_en,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             count_up,
    input  logic             cin_n,
    output logic [WIDTH-1:0] count,
    output logic             cout_n
);

    localparam int TOP_INT = DECIMAL ? 9 : (1 << WIDTH) - 1;
    localparam logic [WIDTH-1:0] TOP_VAL = TOP_INT[WIDTH-1:0];

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] nxt;
    step_t            act;

    updn_decide #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_decide (
        .cur   (count_q),
        .up    (count_up),
        .cin_n (cin_n),
        .act   (act)
    );

    updn_apply #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_apply (
        .cur (count_q),
        .act (act),
        .nxt (nxt)
    );

    updn_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_term (
        .cur    (count_q),
        .up     (count_up),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    // State register: clear beats load, both act without a clock edge.
    always_ff @(posedge clk or posedge clear or posedge load_en) begin
        if (clear) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= preset_val;
        end else begin
            count_q <= nxt;
        end
    end

    assign count = count_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (clear)
        load_en |-> count == preset_val);

    assert_hold_R3: assert property (@(posedge clk) disable iff (clear)
        cin_n |-> nxt == count);

    assert_step_up_R4: assert property (@(posedge clk) disable iff (clear)
        (!cin_n && count_up && count < TOP_VAL) |-> nxt == WIDTH'(count + 1'b1));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (clear)
        (!cin_n && !count_up && count != '0 && count <= TOP_VAL)
            |-> nxt == WIDTH'(count - 1'b1));

    assert_carry_R7: assert property (@(posedge clk) disable iff (clear)
        !cout_n |-> (!cin_n && (count == '0 || count == TOP_VAL)));

    generate
        if (DECIMAL) begin : g_fix_chk
            assert_fix_R8: assert property (@(posedge clk) disable iff (clear)
                (!cin_n && count > TOP_VAL) |-> nxt == (count_up ? '0 : TOP_VAL));
        end
    endgenerate

endmodule

// File: tb/updn_stage_test.sv
module updn_stage_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       clear = 1'b1;
    logic       lo_load = 1'b0, hi_load = 1'b0, b_load = 1'b0;
    logic [3:0] lo_val = '0, hi_val = '0, b_val = '0;
    logic       dir = 1'b1, b_dir = 1'b1;
    logic       cin_n = 1'b1, b_cin_n = 1'b1;
    logic [3:0] lo_q, hi_q, b_q;
    logic       lo_co, hi_co, b_co;

    updn_stage #(.WIDTH(4), .DECIMAL(1'b1)) uut (
        .clk(clk), .clear(clear), .load_en(lo_load), .preset_val(lo_val),
        .count_up(dir), .cin_n(cin_n), .count(lo_q), .cout_n(lo_co));

    updn_stage #(.WIDTH(4), .DECIMAL(1'b1)) uut_hi (
        .clk(clk), .clear(clear), .load_en(hi_load), .preset_val(hi_val),
        .count_up(dir), .cin_n(lo_co), .count(hi_q), .cout_n(hi_co));

    updn_stage #(.WIDTH(4), .DECIMAL(1'b0)) uut_bin (
        .clk(clk), .clear(clear), .load_en(b_load), .preset_val(b_val),
        .count_up(b_dir), .cin_n(b_cin_n), .count(b_q), .cout_n(b_co));

    int compared = 0;
    int mismatched = 0;

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; results are read there too.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        #1;
        clear = 1'b0;
        #1;
    endtask

    task automatic load_pair(input int hi, input int lo);
        hi_val = 4'(hi);
        lo_val = 4'(lo);
        hi_load = 1'b1;
        lo_load = 1'b1;
        #1;
        hi_load = 1'b0;
        lo_load = 1'b0;
        #1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        clear = 1'b1;
        #2;
        chk("R1 low digit on clear", int'(lo_q), 0);
        chk("R1 high digit on clear", int'(hi_q), 0);
        chk("R1 binary on clear", int'(b_q), 0);
        clear = 1'b0;
    endtask

    task automatic test_up_chain();
        @(negedge clk);
        pulse_clear();
        dir = 1'b1;
        cin_n = 1'b0;
        for (int i = 1; i <= 100; i++) begin
            tick();
            chk("R9 up chain value", int'(hi_q) * 10 + int'(lo_q), i % 100);
            chk("R7 up chain carry", int'(hi_co), ((i % 100) == 99) ? 0 : 1);
        end
        chk("R5 up wrap 99->00 low digit", int'(lo_q), 0);
        cin_n = 1'b1;
    endtask

    task automatic test_down_chain();
        @(negedge clk);
        dir = 1'b0;
        cin_n = 1'b0;
        for (int i = 1; i <= 100; i++) begin
            tick();
            chk("R9 down chain value", int'(hi_q) * 10 + int'(lo_q), (100 - i) % 100);
            chk("R7 down chain carry", int'(hi_co), (((100 - i) % 100) == 0) ? 0 : 1);
            if (i == 1) chk("R5 down wrap 0->9", int'(lo_q), 9);
        end
        cin_n = 1'b1;
    endtask

    task automatic test_hold();
        @(negedge clk);
        cin_n = 1'b1;
        dir = 1'b1;
        load_pair(7, 4);
        chk("R2 load without clock", int'(hi_q) * 10 + int'(lo_q), 74);
        repeat (5) tick();
        chk("R3 hold while disabled", int'(hi_q) * 10 + int'(lo_q), 74);
        load_pair(9, 9);
        chk("R7 carry off while disabled low", int'(lo_co), 1);
        chk("R7 carry off while disabled high", int'(hi_co), 1);
        tick();
        chk("R3 hold at terminal", int'(hi_q) * 10 + int'(lo_q), 99);
        cin_n = 1'b0;
        #1;
        chk("R7 carry on at 9 up low", int'(lo_co), 0);
        chk("R7 carry on at 99 up high", int'(hi_co), 0);
        tick();
        chk("R4 step up from 99", int'(hi_q) * 10 + int'(lo_q), 0);
        cin_n = 1'b1;
    endtask

    task automatic test_illegal();
        @(negedge clk);
        cin_n = 1'b1;
        dir = 1'b1;
        load_pair(3, 12);
        chk("R2 illegal decimal load", int'(lo_q), 12);
        chk("R8 no carry from illegal up", int'(lo_co), 1);
        tick();
        chk("R8 illegal holds while disabled", int'(lo_q), 12);
        cin_n = 1'b0;
        tick();
        chk("R8 illegal up goes to 0", int'(lo_q), 0);
        chk("R8 upper digit untouched on up fix", int'(hi_q), 3);
        cin_n = 1'b1;
        dir = 1'b0;
        load_pair(5, 14);
        cin_n = 1'b0;
        #1;
        chk("R8 no carry from illegal down", int'(lo_co), 1);
        tick();
        chk("R8 illegal down goes to 9", int'(lo_q), 9);
        chk("R8 upper digit untouched on down fix", int'(hi_q), 5);
        cin_n = 1'b1;
    endtask

    task automatic test_priority();
        @(negedge clk);
        lo_val = 4'd6;
        clear = 1'b1;
        lo_load = 1'b1;
        #1;
        chk("R1 clear beats load", int'(lo_q), 0);
        lo_load = 1'b0;
        #1;
        clear = 1'b0;
        #1;
        chk("R1 stays cleared after release", int'(lo_q), 0);
    endtask

    task automatic test_binary();
        @(negedge clk);
        pulse_clear();
        b_dir = 1'b1;
        b_cin_n = 1'b0;
        for (int i = 1; i <= 17; i++) begin
            tick();
            chk("R6 binary up value", int'(b_q), i % 16);
            chk("R7 binary up carry", int'(b_co), ((i % 16) == 15) ? 0 : 1);
        end
        b_dir = 1'b0;
        #1;
        chk("R7 binary down carry at 1", int'(b_co), 1);
        tick();
        chk("R4 binary down step", int'(b_q), 0);
        chk("R7 binary down carry at 0", int'(b_co), 0);
        tick();
        chk("R6 binary down wrap 0->15", int'(b_q), 15);
        b_cin_n = 1'b1;
        b_val = 4'd13;
        b_load = 1'b1;
        #1;
        b_load = 1'b0;
        #1;
        chk("R2 binary load", int'(b_q), 13);
    endtask

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        test_up_chain();
        test_down_chain();
        test_hold();
        test_illegal();
        test_priority();
        test_binary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule